// File: doc/BRIEF.md
# System Clock Source Selector with Hardware Fallback

This block chooses which of three clock sources feeds the system clock: the internal RC oscillator, the external crystal oscillator or the PLL. Software asks for a source through a 2-bit request field. The block moves to that source only once the source reports that it is ready. A 2-bit status field shows the source that is actually in use, and a one-hot select drives the downstream clock multiplexer.

Hardware can take the choice away from software. A wake-up from a low-power mode forces the internal oscillator at once. So does a failure of the external oscillator while it clocks the system, either directly or as the PLL reference. In both cases the request field is rewritten to the internal code, so software can see that the override took place. The oscillators and the glitch-free mux cells are outside this block; each source appears here only as a ready flag.

The control is a two-state machine. `ST_STEADY` means the block is running on the current source. `ST_SWITCH` means a change is pending and the block is waiting for the target source to report ready. The transitions are:
- STEADY→SWITCH when the request differs from the current source.
- SWITCH→STEADY when the target becomes ready (commit).
- SWITCH→STEADY when the request returns to the current source (abandon).
- Either state→STEADY on a forced fallback.

Top module: `sysclk_src_sel`

## Requirements
- R1: After reset, req_q and status both read 00 and mux_sel is 3'b001.
- R2: Source codes are 00 for internal, 01 for external and 10 for PLL, in both req_q and status. Status never reads 11.
- R3: A request for a different source changes status two clock edges after the write edge, provided that source's ready flag is high. While the flag is low, status keeps the previous source and the switch stays pending until the flag rises.
- R4: A write with req_wdata = 11 is ignored, and req_q keeps its previous value.
- R5: A wake_evt pulse forces status and req_q to 00 on the next edge. This takes priority over a request write in the same cycle.
- R6: With PLL_FROM_EXT = 1, ext_fail while status is 01 or 10 forces status and req_q to 00 on the next edge.
- R7: ext_fail while status is 00 has no effect. A request pending at that moment is kept.
- R8: mux_sel is one-hot: bit 0 for internal, bit 1 for external, bit 2 for PLL. It always agrees with status.
- R9: If the request returns to the current source while a switch is pending, the switch is abandoned. A later ready on the old target causes no change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset |
| req_wr | input | 1 | Write strobe for the request field |
| req_wdata | input | 2 | Requested source code |
| rdy_int | input | 1 | Internal oscillator ready |
| rdy_ext | input | 1 | External oscillator ready |
| rdy_pll | input | 1 | PLL locked and ready |
| wake_evt | input | 1 | Wake-up from a low-power mode |
| ext_fail | input | 1 | External oscillator failure detected |
| req_q | output | 2 | Current request field |
| mux_sel | output | 3 | One-hot clock mux select |
| status | output | 2 | Source actually in use |

## Verification
The bench builds the block with PLL_FROM_EXT = 1, so the PLL counts as fed by the external oscillator. With that setting, a failure while running on the PLL forces the fallback, which brings the R6 path through the PLL within reach. Failures seen while on the internal oscillator, including those with a switch pending to the PLL, exercise R7. Timing checks sample status after each edge following a write, which pins down the two-edge latency of R3.

// File: rtl/sysclk_pkg.sv
package sysclk_pkg;
    localparam int SRC_W = 2;
    localparam int NSRC  = 3;

    typedef enum logic [SRC_W-1:0] {
        SRC_INT = 2'b00,
        SRC_EXT = 2'b01,
        SRC_PLL = 2'b10
    } src_e;

    localparam logic [SRC_W-1:0] SRC_RSVD = 2'b11;

    typedef enum logic {
        ST_STEADY = 1'b0,
        ST_SWITCH = 1'b1
    } sel_st_e;
endpackage

// File: rtl/clksel_req_reg.sv
module clksel_req_reg
    import sysclk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SRC_W-1:0] wr_data,
    input  logic             force_int,
    output src_e             req_q
);
    // A forced fallback beats a software write; the reserved code is dropped.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q <= SRC_INT;
        end else if (force_int) begin
            req_q <= SRC_INT;
        end else if (wr_en && (wr_data != SRC_RSVD)) begin
            req_q <= src_e'(wr_data);
        end
    end
endmodule

// File: rtl/clksel_fault.sv
module clksel_fault
    import sysclk_pkg::*;
#(
    parameter bit PLL_FROM_EXT = 1'b1
) (
    input  logic wake_evt,
    input  logic ext_fail,
    input  src_e cur,
    output logic force_int
);
    logic ext_in_path;

    generate
        if (PLL_FROM_EXT) begin : g_pll_ext_ref
            assign ext_in_path = (cur == SRC_EXT) || (cur == SRC_PLL);
        end else begin : g_pll_int_ref
            assign ext_in_path = (cur == SRC_EXT);
        end
    endgenerate

    assign force_int = wake_evt || (ext_fail && ext_in_path);
endmodule

// File: rtl/clksel_fsm.sv
module clksel_fsm
    import sysclk_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  src_e            req,
    input  logic [NSRC-1:0] rdy,
    input  logic            force_int,
    output src_e            cur
);
    sel_st_e st_q, st_d;
    src_e    cur_d;
    logic    tgt_rdy;

    always_comb begin
        unique case (req)
            SRC_INT: tgt_rdy = rdy[0];
            SRC_EXT: tgt_rdy = rdy[1];
            SRC_PLL: tgt_rdy = rdy[2];
            default: tgt_rdy = 1'b0;
        endcase
    end

    always_comb begin
        st_d  = st_q;
        cur_d = cur;
        unique case (st_q)
            ST_STEADY: begin
                if (force_int) begin
                    cur_d = SRC_INT;
                end else if (req != cur) begin
                    st_d = ST_SWITCH;
                end
            end
            ST_SWITCH: begin
                if (force_int) begin
                    cur_d = SRC_INT;
                    st_d  = ST_STEADY;
                end else if (req == cur) begin
                    st_d = ST_STEADY;
                end else if (tgt_rdy) begin
                    cur_d = req;
                    st_d  = ST_STEADY;
                end
            end
            default: st_d = ST_STEADY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_STEADY;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur <= SRC_INT;
        else        cur <= cur_d;
    end
endmodule

// File: rtl/clksel_decode.sv
module clksel_decode
    import sysclk_pkg::*;
(
    input  src_e            cur,
    output logic [NSRC-1:0] sel_oh
);
    generate
        for (genvar i = 0; i < NSRC; i++) begin : g_oh
            assign sel_oh[i] = (cur == src_e'(i));
        end
    endgenerate
endmodule

// File: rtl/sysclk_src_sel.sv
module sysclk_src_sel
    import sysclk_pkg::*;
#(
    parameter bit PLL_FROM_EXT = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_wr,
    input  logic [SRC_W-1:0] req_wdata,
    input  logic             rdy_int,
    input  logic             rdy_ext,
    input  logic             rdy_pll,
    input  logic             wake_evt,
    input  logic             ext_fail,
    output logic [SRC_W-1:0] req_q,
    output logic [NSRC-1:0]  mux_sel,
    output logic [SRC_W-1:0] status
);
    src_e req_s, cur_s;
    logic force_int;

    clksel_fault #(.PLL_FROM_EXT(PLL_FROM_EXT)) u_fault (
        .wake_evt  (wake_evt),
        .ext_fail  (ext_fail),
        .cur       (cur_s),
        .force_int (force_int)
    );

    clksel_req_reg u_req (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (req_wr),
        .wr_data   (req_wdata),
        .force_int (force_int),
        .req_q     (req_s)
    );

    clksel_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req_s),
        .rdy       ({rdy_pll, rdy_ext, rdy_int}),
        .force_int (force_int),
        .cur       (cur_s)
    );

    clksel_decode u_dec (
        .cur    (cur_s),
        .sel_oh (mux_sel)
    );

    assign req_q  = req_s;
    assign status = cur_s;
endmodule

// File: rtl/sysclk_src_sel_chk.sv
module sysclk_src_sel_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_wr,
    input logic [1:0] req_wdata,
    input logic       rdy_ext,
    input logic       rdy_pll,
    input logic       wake_evt,
    input logic       ext_fail,
    input logic [1:0] req_q,
    input logic [2:0] mux_sel,
    input logic [1:0] status
);
    AST_STATUS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        status != 2'b11); // R2

    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(mux_sel) == 1 && mux_sel[status] == 1'b1); // R8

    AST_RSVD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_wr && req_wdata == 2'b11 && !wake_evt && !ext_fail)
        |=> req_q == $past(req_q)); // R4

    AST_WAKE_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
        wake_evt |=> (status == 2'b00 && req_q == 2'b00)); // R5

    AST_EXT_FAIL_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_fail && status == 2'b01) |=> (status == 2'b00 && req_q == 2'b00)); // R6

    AST_EXT_NEEDS_RDY: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(status) && status == 2'b01) |-> $past(rdy_ext)); // R3

    AST_PLL_NEEDS_RDY: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(status) && status == 2'b10) |-> $past(rdy_pll)); // R3
endmodule

bind sysclk_src_sel sysclk_src_sel_chk u_chk (.*);

// File: tb/sim_sysclk_src_sel.sv
module sim_sysclk_src_sel;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_wr = 1'b0;
    logic [1:0] req_wdata = 2'b00;
    logic       rdy_int = 1'b1, rdy_ext = 1'b0, rdy_pll = 1'b0;
    logic       wake_evt = 1'b0, ext_fail = 1'b0;
    logic [1:0] req_q, status;
    logic [2:0] mux_sel;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk; // 200 MHz

    sysclk_src_sel #(.PLL_FROM_EXT(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .req_wr(req_wr), .req_wdata(req_wdata),
        .rdy_int(rdy_int), .rdy_ext(rdy_ext), .rdy_pll(rdy_pll),
        .wake_evt(wake_evt), .ext_fail(ext_fail),
        .req_q(req_q), .mux_sel(mux_sel), .status(status)
    );

    // {wr, wdata[1:0], rdy{pll,ext,int}, wake, fail, exp_req[1:0], exp_status[1:0]}
    localparam int NV = 13;
    localparam logic [11:0] VEC [NV] = '{
        12'b1_01_111_00_01_01, // R3 switch to external, ready
        12'b1_10_011_00_10_01, // R3 PLL not ready, stays external
        12'b0_00_111_00_10_10, // R3 PLL ready, pending switch completes
        12'b1_11_111_00_10_10, // R4 reserved code ignored
        12'b0_00_111_01_00_00, // R6 failure while on PLL
        12'b1_01_111_00_01_01, // R2 external code
        12'b0_00_111_01_00_00, // R6 failure while on external
        12'b1_10_001_00_10_00, // R3 pending to PLL, not ready
        12'b0_00_001_01_10_00, // R7 failure while on internal ignored
        12'b1_00_001_00_00_00, // R9 request back to current source
        12'b0_00_111_00_00_00, // R9 late PLL ready causes no switch
        12'b1_01_111_00_01_01, // R2 external again
        12'b0_00_111_10_00_00  // R5 wake forces internal
    };

    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_all(input string req, input logic [1:0] er, input logic [1:0] es);
        chk(req, {2'b00, req_q}, {2'b00, er});
        chk(req, {2'b00, status}, {2'b00, es});
        chk({req, " R8 mux_sel"}, {1'b0, mux_sel}, {1'b0, 3'b001 << es});
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk_all("R1 in reset", 2'b00, 2'b00);
        rst_n = 1'b1;
        @(negedge clk);
        chk_all("R1 after reset", 2'b00, 2'b00);

        for (int i = 0; i < NV; i++) begin
            req_wr    = VEC[i][11];
            req_wdata = VEC[i][10:9];
            {rdy_pll, rdy_ext, rdy_int} = VEC[i][8:6];
            wake_evt  = VEC[i][5];
            ext_fail  = VEC[i][4];
            @(negedge clk);
            req_wr = 1'b0; wake_evt = 1'b0; ext_fail = 1'b0;
            repeat (3) @(negedge clk);
            chk_all($sformatf("vector %0d", i), VEC[i][3:2], VEC[i][1:0]);
        end

        // R3 latency: status changes on the second edge after the write edge
        {rdy_pll, rdy_ext, rdy_int} = 3'b111;
        req_wr = 1'b1; req_wdata = 2'b01;
        @(negedge clk);
        req_wr = 1'b0;
        chk("R3 req after write edge", {2'b00, req_q}, 4'h1);
        chk("R3 status held one edge", {2'b00, status}, 4'h0);
        @(negedge clk);
        chk("R3 status held two edges? no, pending", {2'b00, status}, 4'h0);
        @(negedge clk);
        chk("R3 status after commit", {2'b00, status}, 4'h1);

        // R5: wake beats a same-cycle write, acts in one edge
        req_wr = 1'b1; req_wdata = 2'b10; wake_evt = 1'b1;
        @(negedge clk);
        req_wr = 1'b0; wake_evt = 1'b0;
        chk_all("R5 wake over write", 2'b00, 2'b00);
        repeat (3) @(negedge clk);
        chk_all("R5 no later switch", 2'b00, 2'b00);

        // R1: reset in mid-run
        req_wr = 1'b1; req_wdata = 2'b10;
        @(negedge clk);
        req_wr = 1'b0;
        repeat (3) @(negedge clk);
        chk_all("R1 pre-reset on PLL", 2'b10, 2'b10);
        rst_n = 1'b0;
        @(negedge clk);
        chk_all("R1 reset mid-run", 2'b00, 2'b00);
        rst_n = 1'b1;
        @(negedge clk);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule